// File: doc/BRIEF.md
# Bit-Serial Floating-Point Adder

This block adds two numbers held in a reduced floating-point format. Each number has a sign bit, an unsigned exponent of `EW` bits and a mantissa of `MW` bits. The mantissa's leading bit is stored explicitly. The exponents and signs arrive in parallel with a start strobe. The mantissas arrive one bit per clock, least-significant bit first. The sum leaves the block the same way: one mantissa bit per clock, followed by a one-cycle done strobe that carries the result sign and exponent.

The datapath is one bit wide. The larger operand is scaled by running its bit stream through a delay line whose output tap equals the exponent difference. A one-bit adder/subtractor with a carry flop then produces the exact sum. The sum streams into a second shift register, and a tap chosen by the leading-one position reads the result out already normalised. A serial incrementer rounds the result to nearest on the way out.

There are no infinities, NaNs or denormals. An exponent that leaves its range is clamped to the nearest end of the range. Zero is the only special value. A new operation is taken only from idle, so operations run one at a time with a fixed latency.

Top module: `fpsa_add`

## Requirements
- R1: Operand format. Each operand is a sign (1 = negative), an unsigned exponent of EW bits and an MW-bit mantissa whose top bit is set for every nonzero value. Mantissa bit 0 is presented in the start cycle. Bit k is presented k cycles later, for k from 1 to MW-1. An all-zero mantissa means zero.
- R2: Timing. Start is accepted only when the block is idle, and while an operation runs any start is ignored. The done output is high for exactly one cycle, 3*MW+TAPS+3 cycles after the cycle in which start was accepted.
- R3: Result stream. The result mantissa leaves on resBit, LSB first, during the MW consecutive cycles just before done, with resBitValid high in exactly those cycles. resSign and resExp are valid while done is high.
- R4: When the signs are equal, the result is the exact sum of the magnitudes. It is normalised so that its top mantissa bit is set, then rounded to nearest on the first dropped bit (a half rounds away from zero). A carry past the top mantissa bit raises the exponent by one.
- R5: When the signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. Equal magnitudes give an all-zero result: sign 0, exponent 0, mantissa 0.
- R6: An exponent difference of at most TAPS-1 aligns the smaller operand with no precision lost before the final rounding.
- R7: An exponent difference of TAPS or more treats the smaller operand as zero, so the result equals the larger operand.
- R8: An operand with an all-zero mantissa, of any sign and exponent, leaves the other operand unchanged. Two zero operands give the all-zero result.
- R9: A result exponent above 2^EW-1 is clamped to 2^EW-1. The mantissa stays as rounded.
- R10: A result exponent below 0 is clamped to 0. The mantissa stays normalised and rounded.
- R11: When rounding carries out of a mantissa of all ones, the mantissa becomes 100...0 and the exponent rises by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation; also marks mantissa bit 0 |
| aSign | input | 1 | Sign of operand A, sampled with start |
| aExp | input | EW | Exponent of operand A, sampled with start |
| aBit | input | 1 | Serial mantissa of operand A, LSB first |
| bSign | input | 1 | Sign of operand B, sampled with start |
| bExp | input | EW | Exponent of operand B, sampled with start |
| bBit | input | 1 | Serial mantissa of operand B, LSB first |
| resBit | output | 1 | Serial result mantissa, LSB first |
| resBitValid | output | 1 | Marks the cycles in which resBit carries data |
| resSign | output | 1 | Result sign, valid with done |
| resExp | output | EW | Result exponent, valid with done |
| done | output | 1 | One-cycle completion strobe |

## Verification
The main sweep runs a small configuration. It takes every pairing of zero and normalised mantissas, both sign relations, and exponent pairs that are equal, that differ by less than the tap range and that differ by more than it, near both ends of the exponent range. Equal exponents with equal mantissas separate cancellation to zero from ordinary subtraction. Differences just inside and just past the tap range separate exact alignment from flushing. Operands at the top and bottom exponents expose both clamps. Directed cases add a rounding carry out of an all-ones mantissa and a start pulse issued mid-operation.

// File: rtl/fpsa_pkg.sv
package fpsa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_ADD,
    ST_NORM,
    ST_OUT,
    ST_DONE
  } fpsaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // start taken in idle: latch signs and exponents
    logic capture;   // shift one mantissa bit of each operand in
    logic setup;     // pick larger operand, load serial shifters
    logic addStep;   // one bit of the serial add or subtract
    logic normStep;  // latch leading-one position of the sum
    logic outStep;   // one cycle of the rounding read-out
    logic outFirst;  // read-out cycle that fetches the guard bit
    logic outLast;   // read-out cycle of the top mantissa bit
  } fpsaCtrl_s;

endpackage

// File: rtl/fpsa_tapline.sv
module fpsa_tapline #(
  parameter int DEPTH = 16,
  parameter int SW    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          shift,
  input  logic          din,
  input  logic [SW-1:0] sel,
  output logic          dout
);

  // hist[k] holds the input seen k shift steps earlier
  logic [DEPTH-1:1] hist;

  genvar k;
  for (k = 1; k < DEPTH; k++) begin : gStage
    logic q;
    logic prev;
    if (k == 1) begin : gHead
      assign prev = din;
    end else begin : gBody
      assign prev = gStage[k-1].q;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      q <= 1'b0;
      else if (clr)   q <= 1'b0;
      else if (shift) q <= prev;
    end
    assign hist[k] = q;
  end

  // run-time tap select; tap 0 is the undelayed input
  always_comb begin
    dout = din;
    for (int j = 1; j < DEPTH; j++) begin
      if (sel == SW'(j)) dout = hist[j];
    end
  end

endmodule

// File: rtl/fpsa_ctrl.sv
module fpsa_ctrl
  import fpsa_pkg::*;
#(
  parameter int MW   = 8,
  parameter int TAPS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output fpsaCtrl_s st,
  output logic      done
);

  localparam int SUM_W = MW + TAPS;
  localparam int CW    = $clog2(SUM_W + 1);
  localparam logic [CW-1:0] LOAD_END = CW'(MW - 2);
  localparam logic [CW-1:0] ADD_END  = CW'(SUM_W - 1);
  localparam logic [CW-1:0] OUT_END  = CW'(MW);

  fpsaState_e state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (cnt == LOAD_END) begin
            state <= ST_SETUP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETUP: begin
          state <= ST_ADD;
          cnt   <= '0;
        end
        ST_ADD: begin
          if (cnt == ADD_END) begin
            state <= ST_NORM;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_NORM: begin
          state <= ST_OUT;
          cnt   <= '0;
        end
        ST_OUT: begin
          if (cnt == OUT_END) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    st.accept   = (state == ST_IDLE) && start;
    st.capture  = st.accept || (state == ST_LOAD);
    st.setup    = (state == ST_SETUP);
    st.addStep  = (state == ST_ADD);
    st.normStep = (state == ST_NORM);
    st.outStep  = (state == ST_OUT);
    st.outFirst = (state == ST_OUT) && (cnt == '0);
    st.outLast  = (state == ST_OUT) && (cnt == OUT_END);
    done        = (state == ST_DONE);
  end

endmodule

// File: rtl/fpsa_dpath.sv
module fpsa_dpath
  import fpsa_pkg::*;
#(
  parameter int EW   = 6,
  parameter int MW   = 8,
  parameter int TAPS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  fpsaCtrl_s     st,
  input  logic          aSign,
  input  logic [EW-1:0] aExp,
  input  logic          aBit,
  input  logic          bSign,
  input  logic [EW-1:0] bExp,
  input  logic          bBit,
  output logic          resBit,
  output logic          resBitValid,
  output logic          resSign,
  output logic [EW-1:0] resExp
);

  localparam int SUM_W = MW + TAPS;          // exact sum width incl. carry
  localparam int NORM_W = SUM_W + MW + 1;    // sum plus zero pad below
  localparam int DW = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int PW = $clog2(NORM_W);
  localparam int EMAX = (1 << EW) - 1;
  localparam logic [EW:0] TAP_LIMIT = (EW + 1)'(TAPS - 1);

  // operand capture
  logic          sA, sB;
  logic [EW-1:0] eA, eB;
  logic [MW-1:0] mA, mB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sA <= 1'b0; sB <= 1'b0;
      eA <= '0;   eB <= '0;
      mA <= '0;   mB <= '0;
    end else begin
      if (st.capture) begin
        mA <= {aBit, mA[MW-1:1]};
        mB <= {bBit, mB[MW-1:1]};
      end
      if (st.accept) begin
        sA <= aSign; sB <= bSign;
        eA <= aExp;  eB <= bExp;
      end
    end
  end

  // larger-magnitude selection and alignment distance
  logic          aZero, bZero, aBig, flush;
  logic [EW-1:0] eBig, eSml, expDiff;
  logic [MW-1:0] mBig, mSml;

  always_comb begin
    aZero   = ~|mA;
    bZero   = ~|mB;
    aBig    = !aZero && (bZero || (eA > eB) || ((eA == eB) && (mA >= mB)));
    eBig    = aBig ? eA : eB;
    eSml    = aBig ? eB : eA;
    mBig    = aBig ? mA : mB;
    mSml    = aBig ? mB : mA;
    expDiff = eBig - eSml;
    flush   = (aBig ? bZero : aZero) || ({1'b0, expDiff} > TAP_LIMIT);
  end

  // serial state
  logic              bigSign, subOp, cy, sumZero, rc, ovf;
  logic [EW-1:0]     esEff;
  logic [DW-1:0]     dSel;
  logic [MW-1:0]     bigSh, smallSh;
  logic [NORM_W-1:0] normReg;
  logic [PW-1:0]     pReg, lead;
  logic              found, alignBit, sBit, cyNext, tapBit;
  logic [PW-1:0]     tapIdx;

  fpsa_tapline #(.DEPTH(TAPS), .SW(DW)) uAlign (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (st.setup),
    .shift (st.addStep),
    .din   (bigSh[0]),
    .sel   (dSel),
    .dout  (alignBit)
  );

  // one-bit adder / subtractor (larger minus smaller)
  always_comb begin
    sBit = alignBit ^ smallSh[0] ^ cy;
    if (subOp)
      cyNext = (~alignBit & smallSh[0]) | (~alignBit & cy) | (smallSh[0] & cy);
    else
      cyNext = (alignBit & smallSh[0]) | (alignBit & cy) | (smallSh[0] & cy);
  end

  // leading-one search over the captured sum
  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = MW + 1; i < NORM_W; i++) begin
      if (normReg[i]) begin
        lead  = PW'(i - (MW + 1));
        found = 1'b1;
      end
    end
  end

  // normalising tap: guard bit first, then mantissa bits upward
  assign tapIdx = pReg + PW'(1);
  assign tapBit = normReg[tapIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bigSign <= 1'b0; subOp <= 1'b0; cy <= 1'b0;
      esEff <= '0; dSel <= '0; bigSh <= '0; smallSh <= '0;
      normReg <= '0; pReg <= '0; sumZero <= 1'b1; rc <= 1'b0; ovf <= 1'b0;
    end else if (st.setup) begin
      bigSign <= aBig ? sA : sB;
      subOp   <= sA ^ sB;
      esEff   <= flush ? eBig : eSml;
      dSel    <= flush ? '0 : expDiff[DW-1:0];
      bigSh   <= mBig;
      smallSh <= flush ? '0 : mSml;
      cy      <= 1'b0;
      normReg <= '0;
      ovf     <= 1'b0;
    end else if (st.addStep) begin
      bigSh   <= bigSh >> 1;
      smallSh <= smallSh >> 1;
      cy      <= cyNext;
      normReg <= {sBit, normReg[NORM_W-1:1]};
    end else if (st.normStep) begin
      pReg    <= lead;
      sumZero <= !found;
      rc      <= 1'b0;
    end else if (st.outStep) begin
      normReg <= {1'b0, normReg[NORM_W-1:1]};
      if (st.outFirst) rc <= tapBit;
      else             rc <= tapBit & rc;
      if (st.outLast)  ovf <= tapBit & rc;
    end
  end

  // serial rounding output
  always_comb begin
    resBitValid = st.outStep && !st.outFirst;
    resBit      = resBitValid && ((tapBit ^ rc) || (st.outLast && tapBit && rc));
  end

  // result exponent with saturation
  int expRaw;
  always_comb begin
    expRaw = int'(esEff) + int'(pReg) - (MW - 1) + int'(ovf);
    if (sumZero)            resExp = '0;
    else if (expRaw > EMAX) resExp = EW'(EMAX);
    else if (expRaw < 0)    resExp = '0;
    else                    resExp = EW'(expRaw);
    resSign = !sumZero && bigSign;
  end

endmodule

// File: rtl/fpsa_add.sv
module fpsa_add
  import fpsa_pkg::*;
#(
  parameter int EW   = 6,
  parameter int MW   = 8,
  parameter int TAPS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          aSign,
  input  logic [EW-1:0] aExp,
  input  logic          aBit,
  input  logic          bSign,
  input  logic [EW-1:0] bExp,
  input  logic          bBit,
  output logic          resBit,
  output logic          resBitValid,
  output logic          resSign,
  output logic [EW-1:0] resExp,
  output logic          done
);

  fpsaCtrl_s st;

  fpsa_ctrl #(.MW(MW), .TAPS(TAPS)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .st    (st),
    .done  (done)
  );

  fpsa_dpath #(.EW(EW), .MW(MW), .TAPS(TAPS)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .aSign       (aSign),
    .aExp        (aExp),
    .aBit        (aBit),
    .bSign       (bSign),
    .bExp        (bExp),
    .bBit        (bBit),
    .resBit      (resBit),
    .resBitValid (resBitValid),
    .resSign     (resSign),
    .resExp      (resExp)
  );

endmodule

// File: rtl/fpsa_chk.sv
module fpsa_chk #(
  parameter int MW   = 8,
  parameter int TAPS = 16
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic resBitValid,
  input logic done
);

  localparam int LAT = 3 * MW + TAPS + 3;

  logic        busy;
  logic [15:0] lat, bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; lat <= '0; bitCnt <= '0;
    end else if (!busy && start) begin
      busy <= 1'b1; lat <= 16'd1; bitCnt <= '0;
    end else if (busy) begin
      lat <= lat + 16'd1;
      if (resBitValid) bitCnt <= bitCnt + 16'd1;
      if (done) busy <= 1'b0;
    end
  end

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && lat == 16'(LAT)));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (bitCnt == 16'(MW)));

  assert_valid_in_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    resBitValid |-> (busy && !done));

endmodule

bind fpsa_add fpsa_chk #(.MW(MW), .TAPS(TAPS)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .resBitValid (resBitValid),
  .done        (done)
);

// File: tb/sim_fpsa_add.sv
module sim_fpsa_add;

  localparam int EW   = 4;
  localparam int MW   = 4;
  localparam int TAPS = 4;
  localparam int LAT  = 3 * MW + TAPS + 3;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rstN, start, aSign, aBit, bSign, bBit;
  logic [EW-1:0] aExp, bExp;
  logic resBit, resBitValid, resSign, done;
  logic [EW-1:0] resExp;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fpsa_add #(.EW(EW), .MW(MW), .TAPS(TAPS)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .aSign(aSign), .aExp(aExp), .aBit(aBit),
    .bSign(bSign), .bExp(bExp), .bBit(bBit),
    .resBit(resBit), .resBitValid(resBitValid),
    .resSign(resSign), .resExp(resExp), .done(done)
  );

  // arithmetic reference taken from the requirements
  task automatic model(input int sa, ea, ma, sb, eb, mb,
                       output int rs, re, rm);
    int bigS, bigE, bigM, smE, smM, d, p, m, g, e;
    longint sum;
    bit aBig;
    if (ma == 0 && mb == 0) begin rs = 0; re = 0; rm = 0; return; end
    if (ma == 0) begin rs = sb; re = eb; rm = mb; return; end
    if (mb == 0) begin rs = sa; re = ea; rm = ma; return; end
    aBig = (ea > eb) || (ea == eb && ma >= mb);
    bigS = aBig ? sa : sb; bigE = aBig ? ea : eb; bigM = aBig ? ma : mb;
    smE  = aBig ? eb : ea; smM  = aBig ? mb : ma;
    d = bigE - smE;
    if (d > TAPS - 1) begin rs = bigS; re = bigE; rm = bigM; return; end
    if (sa != sb) sum = (longint'(bigM) << d) - smM;
    else          sum = (longint'(bigM) << d) + smM;
    if (sum == 0) begin rs = 0; re = 0; rm = 0; return; end
    p = 0;
    for (int i = 0; i < 62; i++) if ((sum >> i) & 1) p = i;
    if (p >= MW) begin
      m = int'(sum >> (p - MW + 1));
      g = int'((sum >> (p - MW)) & 1);
    end else begin
      m = int'(sum << (MW - 1 - p));
      g = 0;
    end
    m = m + g;
    e = smE + p - (MW - 1);
    if (m == (1 << MW)) begin m = m >> 1; e = e + 1; end
    if (e > EMAX) e = EMAX;
    if (e < 0) e = 0;
    rs = bigS; re = e; rm = m;
  endtask

  task automatic runOp(input int sa, ea, ma, sb, eb, mb,
                       input string tag, input bit stray);
    int rs, re, rm, n, gotM, bits;
    bit timedOut;
    model(sa, ea, ma, sb, eb, mb, rs, re, rm);
    @(negedge clk);
    start = 1'b1;
    aSign = sa[0]; aExp = EW'(ea); aBit = ma[0];
    bSign = sb[0]; bExp = EW'(eb); bBit = mb[0];
    n = 0; gotM = 0; bits = 0; timedOut = 1'b0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (resBitValid) begin
        gotM = gotM | (int'(resBit) << bits);
        bits++;
      end
      if (done) break;
      if (n > LAT + 30) begin timedOut = 1'b1; break; end
      start = 1'b0;
      if (n < MW) begin
        aBit = ((ma >> n) & 1) != 0;
        bBit = ((mb >> n) & 1) != 0;
      end else begin
        aBit = 1'b0; bBit = 1'b0;
      end
      if (stray && n == MW + 2) begin
        start = 1'b1; aExp = EW'(ea + 3); bExp = EW'(eb + 1);
      end
    end
    start = 1'b0;
    tests++;
    if (timedOut || gotM != rm || int'(resSign) != rs || int'(resExp) != re) begin
      fails++;
      $display("FAIL %s: a=%0d/%0d/%0d b=%0d/%0d/%0d got sign=%0d exp=%0d mant=%0d expected sign=%0d exp=%0d mant=%0d",
               tag, sa, ea, ma, sb, eb, mb, resSign, resExp, gotM, rs, re, rm);
    end
    tests++;
    if (timedOut || n != LAT || bits != MW) begin
      fails++;
      $display("FAIL R2/R3 timing: done after %0d cycles with %0d bits, expected %0d cycles with %0d bits",
               n, bits, LAT, MW);
    end
  endtask

  function automatic string tagFor(int sa, ea, ma, sb, eb, mb);
    int d;
    d = (ea > eb) ? ea - eb : eb - ea;
    if (ma == 0 || mb == 0) return "R8";
    if (d > TAPS - 1) return "R7";
    if (sa != sb) return "R5";
    return "R4";
  endfunction

  initial begin
    int eaL[4];
    eaL = '{0, 2, 13, 15};
    rstN = 1'b0; start = 1'b0;
    aSign = 1'b0; aExp = '0; aBit = 1'b0;
    bSign = 1'b0; bExp = '0; bBit = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tests++;
    if (done !== 1'b0 || resBitValid !== 1'b0) begin
      fails++;
      $display("FAIL R2 reset: done=%0d resBitValid=%0d expected 0 0", done, resBitValid);
    end

    // directed cases
    runOp(0, 3, 8, 0, 3, 8, "R1", 1'b0);
    runOp(0, 5, 9, 0, 5, 8, "R4", 1'b0);
    runOp(0, 3, 8, 0, 0, 15, "R6", 1'b0);
    runOp(0, 9, 8, 0, 0, 15, "R7", 1'b0);
    runOp(1, 12, 0, 1, 2, 11, "R8", 1'b0);
    runOp(0, 4, 12, 1, 4, 12, "R5", 1'b0);
    runOp(0, 4, 10, 1, 4, 12, "R5", 1'b0);
    runOp(0, 15, 15, 0, 15, 15, "R9", 1'b0);
    runOp(0, 0, 15, 1, 0, 14, "R10", 1'b0);
    runOp(0, 3, 9, 1, 0, 9, "R11", 1'b0);
    runOp(0, 6, 13, 0, 4, 11, "R2 stray start", 1'b1);
    runOp(1, 7, 14, 1, 8, 9, "R4", 1'b0);

    // sweep: exponent pairs near both range ends, all mantissa classes
    foreach (eaL[i]) begin
      for (int eb = eaL[i] - 5; eb <= eaL[i] + 5; eb++) begin
        if (eb < 0 || eb > EMAX) continue;
        for (int ma = 0; ma < (1 << MW); ma++) begin
          if (ma != 0 && ma < (1 << (MW - 1))) continue;
          for (int mb = 0; mb < (1 << MW); mb++) begin
            if (mb != 0 && mb < (1 << (MW - 1))) continue;
            for (int sb = 0; sb < 2; sb++) begin
              runOp(0, eaL[i], ma, sb, eb, mb,
                    tagFor(0, eaL[i], ma, sb, eb, mb), 1'b0);
            end
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish in time");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule